// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Port

This block is the slave side of a stereo serial audio link. An external master supplies a bit clock and a frame clock. The port receives one serial data line and assembles left and right receive words. It also serialises a pair of parallel transmit words onto a second line. All logic runs on a fast local clock. The bit clock, frame clock and data input are synchronised into that clock domain and edge-detected there. Each input bit is taken on a detected rising bit-clock edge. The output line changes only after a detected falling bit-clock edge or a frame-clock edge.

A 2-bit format code selects the framing, and the code sets the receive and transmit directions separately. With one code the port can receive right-justified words while it transmits left-justified words. Half-frames of 32 or 24 bit clocks (64 or 48 per frame) are handled with no setting. Reception counts bits from each frame-clock edge, and right-justified reception keeps only the most recent bits before the next edge. The frame length is therefore never needed. The format is meant to be changed only while the port is held in reset.

Top module: `audio_serial_port`

## Requirements
- R1: Format code 00 receives 24-bit MSB-first right-justified words (the last 24 bits before each frame-clock edge) and transmits 24-bit MSB-first left-justified words (MSB in the first bit clock after the edge).
- R2: Format code 01 receives 16-bit MSB-first right-justified words, presented left-aligned as {word[15:0], 8'h00}, and transmits 24-bit left-justified words.
- R3: Format code 10 uses 24-bit MSB-first left-justified framing for both receive and transmit.
- R4: Format code 11 uses 24-bit MSB-first I2S framing in both directions, with the MSB in the second bit clock after the frame-clock edge. With 24-clock half-frames the LSB falls in the first bit clock of the following half-frame.
- R5: In format codes 00, 01 and 10 a high frame clock carries the left channel. In code 11 a low frame clock carries the left channel. The left word appears on rx_left_o and the right word on rx_right_o.
- R6: Frames of 64 and 48 bit clocks both work in every format without any setting.
- R7: Input bits are taken at rising bit-clock edges. sdout_o changes only after a falling bit-clock edge or a frame-clock edge. sdout_o is 0 in every bit clock of a half-frame that carries no transmit word bit.
- R8: Input bits outside the word window are ignored: bits before the last N in right-justified formats, and bits after the word in left-justified and I2S formats.
- R9: rx_valid_o pulses for one clock once per frame, when the right word of a left/right pair completes. rx_right_o changes only together with that pulse. The first frame-clock edge after reset only starts reception.
- R10: During reset sdout_o, rx_left_o, rx_right_o and rx_valid_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock, much faster than the bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fmt_i | input | 2 | Format code (00, 01, 10, 11) |
| bclk_i | input | 1 | External bit clock |
| lrclk_i | input | 1 | External frame clock |
| sdin_i | input | 1 | Serial receive data |
| sdout_o | output | 1 | Serial transmit data |
| tx_left_i | input | 24 | Left transmit word, loaded at the frame-clock edge that starts its half-frame |
| tx_right_i | input | 24 | Right transmit word, loaded at the frame-clock edge that starts its half-frame |
| rx_left_o | output | 24 | Last received left word |
| rx_right_o | output | 24 | Last received right word |
| rx_valid_o | output | 1 | One-clock pulse when a left/right pair completes |

## Verification
The checker tests several rules on every clock. rx_valid_o is never high for two clocks in a row. rx_right_o never moves without that pulse. Receive outputs change only in the clock after a detected rising bit-clock edge. sdout_o changes only in the clock after a detected falling bit-clock edge or frame-clock edge. The data itself is checked only by the bench: bit placement per format, channel polarity, the 16-bit left alignment, the I2S LSB carried across a 24-clock half-frame, ignored filler bits and zero tail bits. The bench sweeps all four format codes at both frame lengths and computes each expected bit and word arithmetically.

// File: rtl/audio_port_pkg.sv
`timescale 1ns/1ps
package audio_port_pkg;
  typedef enum logic [1:0] {
    FMT_RJ24_LJ = 2'b00,
    FMT_RJ16_LJ = 2'b01,
    FMT_LJ      = 2'b10,
    FMT_I2S     = 2'b11
  } fmt_e;

  function automatic logic is_i2s(fmt_e f);
    return f == FMT_I2S;
  endfunction
endpackage

// File: rtl/sap_sync_edge.sv
`timescale 1ns/1ps
module sap_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic lrclk_i,
  input  logic sdin_i,
  output logic bclk_rise_o,
  output logic bclk_fall_o,
  output logic lr_o,
  output logic lr_chg_o,
  output logic sd_o
);
  localparam int unsigned NSIG = 3;

  logic [NSIG-1:0] raw, synced;
  logic bclk_q, lr_q;

  assign raw = {sdin_i, lrclk_i, bclk_i};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '0;
      else         chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= 1'b0;
      lr_q   <= 1'b0;
    end else begin
      bclk_q <= synced[0];
      lr_q   <= synced[1];
    end
  end

  assign bclk_rise_o = synced[0] & ~bclk_q;
  assign bclk_fall_o = ~synced[0] & bclk_q;
  assign lr_o        = synced[1];
  assign lr_chg_o    = synced[1] ^ lr_q;
  assign sd_o        = synced[2];
endmodule

// File: rtl/sap_rx.sv
`timescale 1ns/1ps
module sap_rx
  import audio_port_pkg::*;
#(
  parameter int unsigned WORD_W  = 24,
  parameter int unsigned SHORT_W = 16,
  parameter int unsigned IDX_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  fmt_e              fmt_i,
  input  logic              rise_i,
  input  logic              lr_i,
  input  logic              sd_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};
  localparam logic [IDX_W-1:0] IDX_SPILL = IDX_W'(WORD_W - 1);

  logic              lr_q, primed, have_left, frame_edge, left_done;
  logic [IDX_W-1:0]  idx, idx_nxt;
  logic [WORD_W-1:0] sh, fin;

  // bit index within the half-frame that belongs to the word window
  function automatic logic take(fmt_e f, logic [IDX_W-1:0] i);
    case (f)
      FMT_RJ24_LJ, FMT_RJ16_LJ: take = 1'b1;
      FMT_LJ:  take = int'(i) < WORD_W;
      default: take = (i != '0) && (int'(i) <= WORD_W);
    endcase
  endfunction

  assign frame_edge = lr_i ^ lr_q;
  assign left_done  = is_i2s(fmt_i) ? ~lr_q : lr_q;
  assign idx_nxt    = (idx == IDX_MAX) ? idx : idx + 1'b1;

  always_comb begin
    case (fmt_i)
      FMT_RJ16_LJ: fin = {sh[SHORT_W-1:0], {(WORD_W-SHORT_W){1'b0}}};
      FMT_I2S:     fin = (idx == IDX_SPILL) ? {sh[WORD_W-2:0], sd_i} : sh;
      default:     fin = sh;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_q      <= 1'b0;
      primed    <= 1'b0;
      have_left <= 1'b0;
      idx       <= '0;
      sh        <= '0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (rise_i) begin
        lr_q <= lr_i;
        if (frame_edge) begin
          primed <= 1'b1;
          idx    <= '0;
          sh     <= take(fmt_i, '0) ? WORD_W'(sd_i) : '0;
          if (primed) begin
            if (left_done) begin
              left_o    <= fin;
              have_left <= 1'b1;
            end else if (have_left) begin
              right_o   <= fin;
              valid_o   <= 1'b1;
              have_left <= 1'b0;
            end
          end
        end else begin
          idx <= idx_nxt;
          if (take(fmt_i, idx_nxt)) sh <= {sh[WORD_W-2:0], sd_i};
        end
      end
    end
  end
endmodule

// File: rtl/sap_tx.sv
`timescale 1ns/1ps
module sap_tx
  import audio_port_pkg::*;
#(
  parameter int unsigned WORD_W = 24,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  fmt_e              fmt_i,
  input  logic              fall_i,
  input  logic              lr_i,
  input  logic              lr_chg_i,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  output logic              sd_o
);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};
  localparam logic [IDX_W-1:0] IDX_SPILL = IDX_W'(WORD_W - 1);

  logic [WORD_W-1:0] w, w_new;
  logic [IDX_W-1:0]  p, p_nxt;
  logic              new_left;

  function automatic logic bit_at(fmt_e f, logic [WORD_W-1:0] v, logic [IDX_W-1:0] q);
    int qi;
    qi = int'(q);
    if (is_i2s(f)) bit_at = (qi >= 1 && qi <= WORD_W) ? v[WORD_W-qi] : 1'b0;
    else           bit_at = (qi < WORD_W) ? v[WORD_W-1-qi] : 1'b0;
  endfunction

  assign new_left = is_i2s(fmt_i) ? ~lr_i : lr_i;
  assign w_new    = new_left ? left_i : right_i;
  assign p_nxt    = (p == IDX_MAX) ? p : p + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w    <= '0;
      p    <= '0;
      sd_o <= 1'b0;
    end else if (lr_chg_i) begin
      w <= w_new;
      p <= '0;
      // I2S: a 24-clock half leaves the old LSB for this slot
      if (is_i2s(fmt_i)) sd_o <= (p == IDX_SPILL) ? w[0] : 1'b0;
      else               sd_o <= w_new[WORD_W-1];
    end else if (fall_i) begin
      p    <= p_nxt;
      sd_o <= bit_at(fmt_i, w, p_nxt);
    end
  end
endmodule

// File: rtl/audio_serial_port.sv
`timescale 1ns/1ps
module audio_serial_port
  import audio_port_pkg::*;
#(
  parameter int unsigned WORD_W      = 24,
  parameter int unsigned SHORT_W     = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IDX_W       = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        fmt_i,
  input  logic              bclk_i,
  input  logic              lrclk_i,
  input  logic              sdin_i,
  output logic              sdout_o,
  input  logic [WORD_W-1:0] tx_left_i,
  input  logic [WORD_W-1:0] tx_right_i,
  output logic [WORD_W-1:0] rx_left_o,
  output logic [WORD_W-1:0] rx_right_o,
  output logic              rx_valid_o
);
  fmt_e fmt;
  logic bclk_rise, bclk_fall, lr_s, lr_chg, sd_s;

  assign fmt = fmt_e'(fmt_i);

  sap_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .bclk_i, .lrclk_i, .sdin_i,
    .bclk_rise_o(bclk_rise), .bclk_fall_o(bclk_fall),
    .lr_o(lr_s), .lr_chg_o(lr_chg), .sd_o(sd_s)
  );

  sap_rx #(.WORD_W(WORD_W), .SHORT_W(SHORT_W), .IDX_W(IDX_W)) u_rx (
    .clk_i, .rst_ni, .fmt_i(fmt), .rise_i(bclk_rise), .lr_i(lr_s), .sd_i(sd_s),
    .left_o(rx_left_o), .right_o(rx_right_o), .valid_o(rx_valid_o)
  );

  sap_tx #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_tx (
    .clk_i, .rst_ni, .fmt_i(fmt), .fall_i(bclk_fall), .lr_i(lr_s), .lr_chg_i(lr_chg),
    .left_i(tx_left_i), .right_i(tx_right_i), .sd_o(sdout_o)
  );
endmodule

// File: rtl/sap_checker.sv
`timescale 1ns/1ps
module sap_checker #(
  parameter int unsigned WORD_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_valid_o,
  input logic [WORD_W-1:0] rx_left_o,
  input logic [WORD_W-1:0] rx_right_o,
  input logic              sdout_o,
  input logic              bclk_rise,
  input logic              bclk_fall,
  input logic              lr_chg
);
  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o); // R9

  AST_RIGHT_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_right_o) |-> rx_valid_o); // R9

  AST_RX_AFTER_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(rx_left_o) || rx_valid_o) |-> $past(bclk_rise)); // R7

  AST_SDOUT_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdout_o) |-> $past(bclk_fall || lr_chg)); // R7
endmodule

bind audio_serial_port sap_checker #(.WORD_W(WORD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_valid_o(rx_valid_o),
  .rx_left_o(rx_left_o), .rx_right_o(rx_right_o), .sdout_o(sdout_o),
  .bclk_rise(bclk_rise), .bclk_fall(bclk_fall), .lr_chg(lr_chg)
);

// File: tb/audio_serial_port_test.sv
`timescale 1ns/1ps
module audio_serial_port_test;
  localparam int H  = 6;   // local clocks per bit-clock phase
  localparam int NF = 6;   // frames per configuration

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic        bclk = 1'b1, lrclk = 1'b0, sdin = 1'b0;
  logic        sdout;
  logic [23:0] tx_left = '0, tx_right = '0;
  logic [23:0] rx_left, rx_right;
  logic        rx_valid;

  int checks = 0, failures = 0;
  int vcnt = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  logic [23:0] exp_l [NF];
  logic [23:0] exp_r [NF];
  string mon_tag;

  always #2 clk = ~clk;

  audio_serial_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .fmt_i(fmt), .bclk_i(bclk), .lrclk_i(lrclk),
    .sdin_i(sdin), .sdout_o(sdout), .tx_left_i(tx_left), .tx_right_i(tx_right),
    .rx_left_o(rx_left), .rx_right_o(rx_right), .rx_valid_o(rx_valid)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic rx_bit(int f, int bph, int k, logic [23:0] w, logic [23:0] prv);
    case (f)
      0: return (k >= bph - 24) ? w[bph-1-k] : 1'b1;
      1: return (k >= bph - 16) ? w[bph-1-k] : 1'b1;
      2: return (k < 24) ? w[23-k] : 1'b1;
      default: begin
        if (k == 0) return (bph == 24) ? prv[0] : 1'b1;
        return (k <= 24) ? w[24-k] : 1'b1;
      end
    endcase
  endfunction

  function automatic logic tx_bit(int f, int bph, int k, logic [23:0] w, logic [23:0] prv);
    if (f == 3) begin
      if (k == 0) return (bph == 24) ? prv[0] : 1'b0;
      return (k <= 24) ? w[24-k] : 1'b0;
    end
    return (k < 24) ? w[23-k] : 1'b0;
  endfunction

  task automatic slot(logic lr, logic d, bit do_chk, logic exp_sd, string req);
    lrclk = lr; sdin = d; bclk = 1'b0;
    repeat (H) @(negedge clk);
    if (do_chk) chk(req, "sdout", {31'b0, sdout}, {31'b0, exp_sd});
    bclk = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (mon_on && rst_ni && rx_valid) begin
      if (vcnt < NF) begin
        chk(mon_tag, "rx_left", {8'b0, rx_left}, {8'b0, exp_l[vcnt]});
        chk(mon_tag, "rx_right", {8'b0, rx_right}, {8'b0, exp_r[vcnt]});
      end
      vcnt++;
    end
  end

  task automatic run_cfg(int f, int bph, int cfg);
    string base, tag;
    logic left_lvl;
    logic [23:0] prv_rx, prv_tx, wl, wr, tl, tr;
    base = (f == 0) ? "R1" : (f == 1) ? "R2" : (f == 2) ? "R3" : "R4";
    if (bph == 24) base = {base, " R6"};
    mon_on = 1'b0;
    rst_ni = 1'b0; fmt = f[1:0]; bclk = 1'b1; lrclk = 1'b0; sdin = 1'b0;
    tx_left = 24'h000000; tx_right = 24'h5A5A5B;
    repeat (4) @(negedge clk);
    chk("R10", "sdout in reset", {31'b0, sdout}, 32'h0);
    chk("R10", "rx_left in reset", {8'b0, rx_left}, 32'h0);
    chk("R10", "rx_right in reset", {8'b0, rx_right}, 32'h0);
    chk("R10", "rx_valid in reset", {31'b0, rx_valid}, 32'h0);
    for (int fr = 0; fr < NF; fr++) begin
      wl = 24'((fr + cfg + 1) * 24'h13579B ^ 24'h8E1C3D);
      wr = 24'((fr + cfg + 3) * 24'h2468AD ^ 24'h71B2C9);
      exp_l[fr] = (f == 1) ? {wl[15:0], 8'h00} : wl;
      exp_r[fr] = (f == 1) ? {wr[15:0], 8'h00} : wr;
    end
    vcnt = 0;
    mon_tag = {base, " R5 R8"};
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;
    left_lvl = (f == 3) ? 1'b0 : 1'b1;
    prv_rx = 24'hFFFFFF;
    prv_tx = 24'h5A5A5B;
    for (int k = 0; k < bph; k++) slot(~left_lvl, 1'b1, 1'b0, 1'b0, base);
    for (int fr = 0; fr < NF; fr++) begin
      wl = 24'((fr + cfg + 1) * 24'h13579B ^ 24'h8E1C3D);
      wr = 24'((fr + cfg + 3) * 24'h2468AD ^ 24'h71B2C9);
      tl = 24'((fr + cfg + 5) * 24'h0F1E2D ^ 24'hC3A517);
      tr = 24'((fr + cfg + 7) * 24'h3C4B5A ^ 24'h2B6E91);
      tx_left = tl; tx_right = tr;
      for (int k = 0; k < bph; k++) begin
        tag = (tx_bit(f, bph, k, 24'h0, 24'h0) == 1'b0 && k >= 25) ? {base, " R7"} : base;
        slot(left_lvl, rx_bit(f, bph, k, wl, prv_rx), 1'b1, tx_bit(f, bph, k, tl, prv_tx), tag);
      end
      prv_rx = wl; prv_tx = tl;
      for (int k = 0; k < bph; k++) begin
        tag = (k >= 25) ? {base, " R7"} : base;
        slot(~left_lvl, rx_bit(f, bph, k, wr, prv_rx), 1'b1, tx_bit(f, bph, k, tr, prv_tx), tag);
      end
      prv_rx = wr; prv_tx = tr;
    end
    for (int k = 0; k < 4; k++) slot(left_lvl, rx_bit(f, bph, k, 24'h0, prv_rx), 1'b0, 1'b0, base);
    repeat (10) @(negedge clk);
    chk({base, " R9"}, "valid pulses", vcnt, NF);
    mon_on = 1'b0;
  endtask

  initial begin
    int cfg;
    cfg = 0;
    for (int f = 0; f < 4; f++) begin
      run_cfg(f, 32, cfg); cfg++;
      run_cfg(f, 24, cfg); cfg++;
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule